// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier for Sign-Magnitude Operands

This block multiplies two sign-magnitude numbers over several clock cycles. A start strobe loads an N-bit multiplicand magnitude and an N-bit multiplier magnitude, each with its own sign bit. For each multiplier bit, taken from the least significant end, the block adds the multiplicand into an upper partial-product register or skips the add. It then moves the whole carry/upper/lower chain one place to the right. After N steps the lower half of the chain has taken in every multiplier bit, and the chain holds the 2N-bit product magnitude.

The sign path is separate from the magnitude path. The product sign is the exclusive OR of the two operand signs. It is forced positive when either magnitude is zero, so the block never produces a negative zero. The add and the shift for one bit happen in the same cycle. The latency is therefore fixed: `done` pulses exactly N cycles after the clock edge that accepts `start`. The result stays on the outputs until the next accepted start.

Top module: `smm_mult`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released until the first start, `busy`, `done`, `prod_sign` and every bit of `prod_mag` are 0.
- R2: A `start` sampled high while `busy` is 0 is accepted: `busy` is 1 from the next cycle. Exactly N cycles after the accepting edge, `done` is 1 and `busy` returns to 0 in the same cycle.
- R3: When `done` is 1, `prod_mag` equals the unsigned product of the two accepted magnitudes. `prod_mag` and `prod_sign` hold those values while the block stays idle.
- R4: When both accepted magnitudes are non-zero, `prod_sign` equals the exclusive OR of `mcand_sign` and `mplr_sign` (1 means negative).
- R5: When either accepted magnitude is zero, `prod_sign` is 0 and `prod_mag` is 0.
- R6: A `start` sampled while `busy` is 1 is ignored. The running operation finishes at its original time with its original operands.
- R7: `done` is high for a single cycle per accepted start.
- R8: A carry out of the upper partial-product add is not lost: all-ones operands give (2^N-1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiplication when idle |
| mcand_mag | input | N | Multiplicand magnitude |
| mcand_sign | input | 1 | Multiplicand sign, 1 = negative |
| mplr_mag | input | N | Multiplier magnitude |
| mplr_sign | input | 1 | Multiplier sign, 1 = negative |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_mag | output | 2N | Product magnitude |
| prod_sign | output | 1 | Product sign, 1 = negative |

## Verification
The multiplier is exercised with several kinds of operands. A sparse multiplier with mixed bits separates real per-bit add-or-skip behaviour from a datapath that always adds. Single-bit operands test the alignment of the shift. All-ones magnitudes show whether the carry bit enters the upper half. Zero magnitudes with negative signs show whether the negative-zero suppression works. Each sign combination confirms the exclusive-OR rule. A start pulse injected in the middle of an operation separates a design that ignores it from one that restarts or corrupts its operands. Cycle-by-cycle sampling of `busy` and `done` pins down the fixed latency.

// File: rtl/smm_pkg.sv
package smm_pkg;
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/smm_step_count.sv
module smm_step_count #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic start_in,
  output logic run_o,
  output logic last_o
);
  localparam int CW = smm_pkg::cnt_bits(N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)                cnt_d = CW'(N);
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_o  = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  // R6: a start arriving mid-run does not reload the counter
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && start_in) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/smm_datapath.sv
module smm_datapath #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplr,
  output logic [2*N-1:0] prod
);
  logic [N-1:0] b_q, a_q, q_q;
  logic [N-1:0] b_d, a_d, q_d;
  logic [N:0]   sum;      // carry:upper, the E:A pair
  logic         reg_en;

  always_comb begin
    sum    = q_q[0] ? ({1'b0, a_q} + {1'b0, b_q}) : {1'b0, a_q};
    reg_en = load || step;
    b_d    = b_q;
    a_d    = a_q;
    q_d    = q_q;
    if (load) begin
      b_d = mcand;
      a_d = '0;
      q_d = mplr;
    end else if (step) begin
      a_d = sum[N:1];
      q_d = {sum[0], q_q[N-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      a_q <= '0;
      q_q <= '0;
    end else if (reg_en) begin
      b_q <= b_d;
      a_q <= a_d;
      q_q <= q_d;
    end
  end

  assign prod = {a_q, q_q};

  // R3: a zero multiplier bit only shifts the upper half
  p_skip_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !q_q[0]) |=> (a_q == ($past(a_q) >> 1)));
  // R3: multiplicand register is frozen during a run
  p_mcand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(b_q));
endmodule

// File: rtl/smm_sign.sv
module smm_sign #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         sa,
  input  logic         sb,
  input  logic [N-1:0] ma,
  input  logic [N-1:0] mb,
  output logic         sign_o
);
  logic sign_q, sign_d, any_zero;

  always_comb begin
    any_zero = (ma == '0) || (mb == '0);
    sign_d   = (sa ^ sb) & ~any_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sign_q <= 1'b0;
    else if (load) sign_q <= sign_d;
  end

  assign sign_o = sign_q;

  // R5: a zero operand always yields a positive sign
  p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (ma == '0)) |=> !sign_o);
endmodule

// File: rtl/smm_mult.sv
module smm_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand_mag,
  input  logic           mcand_sign,
  input  logic [N-1:0]   mplr_mag,
  input  logic           mplr_sign,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] prod_mag,
  output logic           prod_sign
);
  logic rst_meta_q, rst_sync_q;
  logic run, last, accept, done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign accept = start && !run;

  smm_step_count #(.N(N)) u_count (
    .clk(clk), .rst_n(rst_sync_q), .load(accept), .start_in(start),
    .run_o(run), .last_o(last)
  );

  smm_datapath #(.N(N)) u_dp (
    .clk(clk), .rst_n(rst_sync_q), .load(accept), .step(run),
    .mcand(mcand_mag), .mplr(mplr_mag), .prod(prod_mag)
  );

  smm_sign #(.N(N)) u_sign (
    .clk(clk), .rst_n(rst_sync_q), .load(accept),
    .sa(mcand_sign), .sb(mplr_sign), .ma(mcand_mag), .mb(mplr_mag),
    .sign_o(prod_sign)
  );

  always_comb done_d = run && last;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign busy = run;
  assign done = done_q;

  // R2: an accepted start makes the block busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (start && !busy) |=> busy);
  // R2: done follows a busy cycle and coincides with idle
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> ($past(busy) && !busy));
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |=> !done);
  // R5: never a negative zero at completion
  p_no_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> !(prod_sign && (prod_mag == '0)));
endmodule

// File: tb/smm_mult_bench.sv
module smm_mult_bench;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [N-1:0]   mcand_mag, mplr_mag;
  logic           mcand_sign, mplr_sign;
  logic           busy, done, prod_sign;
  logic [2*N-1:0] prod_mag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  smm_mult #(.N(N)) u_smm_mult (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_mag(mcand_mag), .mcand_sign(mcand_sign),
    .mplr_mag(mplr_mag), .mplr_sign(mplr_sign),
    .busy(busy), .done(done), .prod_mag(prod_mag), .prod_sign(prod_sign)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  // One multiplication; poke > 0 injects a start in step poke (R6)
  task automatic do_mul(input logic [N-1:0] a, input logic sa,
                        input logic [N-1:0] b, input logic sb,
                        input int poke, input string tag);
    logic [2*N-1:0] exp_mag;
    logic           exp_sign;
    exp_mag  = (2*N)'(a) * (2*N)'(b);
    exp_sign = (sa ^ sb) && (a != 0) && (b != 0);
    @(negedge clk);
    start = 1'b1; mcand_mag = a; mcand_sign = sa; mplr_mag = b; mplr_sign = sb;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {"R2 busy after start ", tag}, longint'(busy), 1);
    for (int j = 1; j <= N; j++) begin
      @(negedge clk);
      start = 1'b0;
      mcand_mag = a; mplr_mag = b; mcand_sign = sa; mplr_sign = sb;
      if (j == N) begin
        check(done === 1'b1 && busy === 1'b0, {"R2 done at N ", tag},
              longint'({done, busy}), 2);
      end else if (done !== 1'b0 || busy !== 1'b1) begin
        check(1'b0, {"R2 early done ", tag}, longint'({done, busy}), 1);
      end
      if (j == poke) begin
        start = 1'b1; mcand_mag = ~a; mplr_mag = b ^ 8'h5A;
        mcand_sign = ~sa; mplr_sign = ~sb;
      end
    end
    check(prod_mag === exp_mag, {"R3 magnitude ", tag}, longint'(prod_mag), longint'(exp_mag));
    check(prod_sign === exp_sign, {"R4/R5 sign ", tag}, longint'(prod_sign), longint'(exp_sign));
    repeat (3) @(negedge clk);
    check(done === 1'b0, {"R7 single pulse ", tag}, longint'(done), 0);
    check(prod_mag === exp_mag && prod_sign === exp_sign, {"R3 hold ", tag},
          longint'(prod_mag), longint'(exp_mag));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0;
    mcand_mag = '0; mplr_mag = '0; mcand_sign = 1'b0; mplr_sign = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && prod_sign === 0 && prod_mag === '0,
          "R1 in reset", longint'(prod_mag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 0 && done === 0 && prod_sign === 0 && prod_mag === '0,
          "R1 after release", longint'({busy, done}), 0);
  endtask

  task automatic t_mixed_bits();   // R3 R4 sparse multiplier, positive
    do_mul(8'd25, 1'b0, 8'd19, 1'b0, 0, "25x19");
    do_mul(8'd13, 1'b1, 8'd11, 1'b1, 0, "-13x-11");
    do_mul(8'd100, 1'b0, 8'd3, 1'b1, 0, "100x-3");
  endtask

  task automatic t_single_bits();  // R3 shift alignment
    do_mul(8'd1, 1'b1, 8'd1, 1'b0, 0, "-1x1");
    do_mul(8'd128, 1'b0, 8'd2, 1'b0, 0, "128x2");
  endtask

  task automatic t_all_ones();     // R8 carry into upper half
    do_mul(8'hFF, 1'b1, 8'hFF, 1'b0, 0, "R8 255x255");
  endtask

  task automatic t_zero();         // R5 no negative zero
    do_mul(8'd0, 1'b1, 8'd37, 1'b0, 0, "R5 0x37");
    do_mul(8'd44, 1'b0, 8'd0, 1'b1, 0, "R5 44x0");
  endtask

  task automatic t_busy_start();   // R6 start while busy ignored
    do_mul(8'd77, 1'b0, 8'd201, 1'b1, 3, "R6 poke");
  endtask

  initial begin
    t_reset();
    t_mixed_bits();
    t_single_bits();
    t_all_ones();
    t_zero();
    t_busy_start();
    finish_run();
  end
endmodule